// File: doc/BRIEF.md
# Dual-Clock Serial Bit FIFO

This block is an elastic store for a serial bit stream that crosses from one clock domain into another. A producer clocks single bits in on its own write clock and a consumer takes them out on its own read clock. The two clocks run freely and need not be related in frequency or phase. Neither side ever has to look at the other side's clock.

The read port is look-ahead. The oldest bit sits ready on the output, and a ready flag qualifies it. A read acknowledges that bit, and the next stored bit then moves into the output register by itself. The bit held in the output register is not part of the storage fill. A completely full block therefore holds the storage depth plus one bit.

Two status outputs, both in the write domain, report the fill level. One marks half full. The other marks that the block is close to either end.

Top module: `serial_elastic_fifo`

## Requirements
- R1: The storage holds DEPTH bits (default 64; 256 must also work). Starting from empty with no reads, exactly DEPTH+1 bits are accepted before `in_ready` falls: DEPTH in storage and one in the output register. Bits leave in the order they were accepted.
- R2: A bit is taken on a rising `wr_clk` edge only when `wr_en` and `in_ready` are both high. A write attempted while `in_ready` is low adds no bit to the stream.
- R3: A bit is consumed on a rising `rd_clk` edge only when `rd_en` and `out_ready` are both high. A read attempted while `out_ready` is low removes nothing, and the next bit written is the next one read.
- R4: A bit written into an empty block becomes visible through three read-clock synchronizer stages. `out_ready` rises on the 4th rising `rd_clk` edge after the write edge.
- R5: The read-side state reaches the write side through two write-clock stages. After one read from a full block, `in_ready` rises on the 2nd rising `wr_clk` edge after the read edge.
- R6: `half_full` is high exactly when the stored count (excluding the output register) is at least DEPTH/2.
- R7: `near_edge` is high exactly when the stored count is at most NEAR (default 8) or the free storage is at most NEAR.
- R8: While `out_ready` is high, `rd_bit` holds the oldest unread bit and stays stable until it is read. After a read, the next stored bit moves into the output with no further request.
- R9: While `rst_n` is low, and after it is released, both pointers and the output register are cleared. Once the domains leave reset, `in_ready`=1, `out_ready`=0, `half_full`=0 and `near_edge`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_bit | input | 1 | Serial data bit to store |
| in_ready | output | 1 | High when storage can take a bit |
| half_full | output | 1 | Stored count at least DEPTH/2 (write domain) |
| near_edge | output | 1 | Stored count or free space at most NEAR (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read acknowledge for the bit on `rd_bit` |
| rd_bit | output | 1 | Oldest unread bit |
| out_ready | output | 1 | High when `rd_bit` is valid |

## Verification
The bench fills the block one bit at a time and checks both flags at every fill level. This catches an off-by-one threshold, or a count that includes the output register, which would move each flag edge by one position. It fills to the limit and measures that exactly DEPTH+1 bits get in. It then keeps writing against a low `in_ready`: a design that lets those writes through would deliver extra bits during the drain. It measures the flag latency in clock edges in both directions, so a synchronizer chain that is one stage too short or too long shows up as a wrong edge count. It holds read requests on an empty block, runs a long stream on unrelated clocks under read back-pressure, and resets the block while it holds data. A phantom read, a reordered bit or a reset that leaves state behind each shows up as a bit mismatch or a wrong flag.

// File: rtl/sef_pkg.sv
package sef_pkg;
  // Shared defaults for the serial elastic FIFO
  localparam int unsigned SEF_DEPTH_DEFAULT = 64;
  localparam int unsigned SEF_NEAR_DEFAULT  = 8;
  localparam int unsigned SEF_WR_SYNC       = 2;  // stages toward the write domain
  localparam int unsigned SEF_RD_SYNC       = 3;  // stages toward the read domain

  // Pointer width: address bits plus one wrap bit
  function automatic int unsigned sef_ptr_width(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/sef_rst_sync.sv
module sef_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  // Asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/sef_sync.sv
module sef_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[gi] <= '0;
        else        stg_q[gi] <= stg_q[gi-1];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sef_gray2bin.sv
module sef_gray2bin #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    bin[W-1] = gray[W-1];
    for (int i = int'(W) - 2; i >= 0; i--) begin
      bin[i] = bin[i+1] ^ gray[i];
    end
  end
endmodule

// File: rtl/sef_store.sv
module sef_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  // Bit array: written in the write domain, read without a clock from the read side.
  // The read side reads an entry only after its write has been seen through the synchronizer.
  logic mem_q [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem_q[waddr] <= wbit;
  end

  assign rbit = mem_q[raddr];
endmodule

// File: rtl/sef_wr_side.sv
module sef_wr_side #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned NEAR  = 8,
  parameter int unsigned PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rd_gray_s,
  output logic          wr_fire,
  output logic [PW-2:0] wr_addr,
  output logic [PW-1:0] wr_gray,
  output logic          in_ready,
  output logic          half_full,
  output logic          near_edge
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] NEAR_P  = PW'(NEAR);

  logic [PW-1:0] wr_bin_q, wr_bin_d, wr_gray_d;
  logic [PW-1:0] rd_bin_s;
  logic [PW-1:0] fill, free_cnt;

  sef_gray2bin #(.W(PW)) u_rd_conv (.gray(rd_gray_s), .bin(rd_bin_s));

  // Fill level, excluding the bit held in the read-side output register
  always_comb begin
    fill      = wr_bin_q - rd_bin_s;
    free_cnt  = DEPTH_P - fill;
    in_ready  = (fill != DEPTH_P);
    half_full = (fill >= HALF_P);
    near_edge = (fill <= NEAR_P) || (free_cnt <= NEAR_P);
  end

  // Next state
  always_comb begin
    wr_fire   = wr_en && in_ready;
    wr_bin_d  = wr_fire ? wr_bin_q + 1'b1 : wr_bin_q;
    wr_gray_d = wr_bin_d ^ (wr_bin_d >> 1);
  end

  // State
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin_q <= '0;
      wr_gray  <= '0;
    end else if (wr_fire) begin
      wr_bin_q <= wr_bin_d;
      wr_gray  <= wr_gray_d;
    end
  end

  assign wr_addr = wr_bin_q[PW-2:0];

  // R1: the fill never exceeds the storage depth
  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH_P);
  // R2: a write refused for lack of room leaves the write pointer unchanged
  a_r2_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_ready) |=> (wr_bin_q == $past(wr_bin_q)));
  // R2: the published write pointer moves by at most one Gray bit per edge
  a_r2_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  // R6: half_full can only go up just after an accepted write
  a_r6_hf_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_full) |-> $past(wr_fire));
endmodule

// File: rtl/sef_rd_side.sv
module sef_rd_side #(
  parameter int unsigned PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wr_gray_s,
  input  logic          mem_bit,
  output logic [PW-2:0] rd_addr,
  output logic [PW-1:0] rd_gray,
  output logic          out_ready,
  output logic          rd_bit
);
  logic [PW-1:0] rd_bin_q, rd_bin_d, rd_gray_d;
  logic          out_valid_q, out_valid_d;
  logic          stored_any, take, load;

  // Next state: consume the output bit, and refill the output register from storage
  always_comb begin
    stored_any  = (rd_gray != wr_gray_s);
    take        = out_valid_q && rd_en;
    load        = stored_any && (!out_valid_q || take);
    rd_bin_d    = load ? rd_bin_q + 1'b1 : rd_bin_q;
    rd_gray_d   = rd_bin_d ^ (rd_bin_d >> 1);
    out_valid_d = load ? 1'b1 : (take ? 1'b0 : out_valid_q);
  end

  // Pointer and flag state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin_q    <= '0;
      rd_gray     <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      if (load) begin
        rd_bin_q <= rd_bin_d;
        rd_gray  <= rd_gray_d;
      end
    end
  end

  // Output bit register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_bit <= 1'b0;
    else if (load) rd_bit <= mem_bit;
  end

  assign rd_addr   = rd_bin_q[PW-2:0];
  assign out_ready = out_valid_q;

  // R8: an unread output bit stays valid and unchanged
  a_r8_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !rd_en) |=> (out_valid_q && $stable(rd_bit)));
  // R4: the output becomes valid only when the synchronized write pointer showed stored data
  a_r4_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_q) |-> $past(stored_any));
  // R3: the published read pointer moves by at most one Gray bit per edge
  a_r3_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/serial_elastic_fifo.sv
module serial_elastic_fifo #(
  parameter int unsigned DEPTH = sef_pkg::SEF_DEPTH_DEFAULT,
  parameter int unsigned NEAR  = sef_pkg::SEF_NEAR_DEFAULT
) (
  input  logic rst_n,
  input  logic wr_clk,
  input  logic wr_en,
  input  logic wr_bit,
  output logic in_ready,
  output logic half_full,
  output logic near_edge,
  input  logic rd_clk,
  input  logic rd_en,
  output logic rd_bit,
  output logic out_ready
);
  localparam int unsigned PW = sef_pkg::sef_ptr_width(DEPTH);
  localparam int unsigned AW = PW - 1;

  logic          w_rst_n, r_rst_n;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          wr_fire, mem_bit;

  sef_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(w_rst_n));
  sef_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(r_rst_n));

  // Read pointer toward the write domain: two stages
  sef_sync #(.W(PW), .STAGES(sef_pkg::SEF_WR_SYNC)) u_rd2wr (
    .clk(wr_clk), .rst_n(w_rst_n), .d(rd_gray), .q(rd_gray_ws));

  // Write pointer toward the read domain: three stages
  sef_sync #(.W(PW), .STAGES(sef_pkg::SEF_RD_SYNC)) u_wr2rd (
    .clk(rd_clk), .rst_n(r_rst_n), .d(wr_gray), .q(wr_gray_rs));

  sef_wr_side #(.DEPTH(DEPTH), .NEAR(NEAR), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(w_rst_n), .wr_en(wr_en), .rd_gray_s(rd_gray_ws),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_gray(wr_gray),
    .in_ready(in_ready), .half_full(half_full), .near_edge(near_edge));

  sef_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .wr_clk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wbit(wr_bit),
    .raddr(rd_addr), .rbit(mem_bit));

  sef_rd_side #(.PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(r_rst_n), .rd_en(rd_en), .wr_gray_s(wr_gray_rs),
    .mem_bit(mem_bit), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .out_ready(out_ready), .rd_bit(rd_bit));
endmodule

// File: tb/test_serial_elastic_fifo.sv
`timescale 1ns/100ps
module test_serial_elastic_fifo;
  localparam int DEPTH = 64;
  localparam int NEAR  = 8;

  logic rst_n, wr_clk, wr_en, wr_bit, rd_clk, rd_en;
  logic in_ready, half_full, near_edge, rd_bit, out_ready;

  int checks = 0;
  int failures = 0;
  bit expq [0:8191];
  int qh = 0;
  int qt = 0;
  bit finished = 0;

  serial_elastic_fifo #(.DEPTH(DEPTH), .NEAR(NEAR)) i_serial_elastic_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_bit(wr_bit),
    .in_ready(in_ready), .half_full(half_full), .near_edge(near_edge),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_bit(rd_bit), .out_ready(out_ready));

  // 100 MHz write clock; unrelated read clock whose edges never coincide with it
  initial begin wr_clk = 0; forever #5 wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; #0.5; forever #7 rd_clk = ~rd_clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int i);
    return bit'((i ^ (i >> 2) ^ (i >> 5) ^ (i * 3)) & 1);
  endfunction

  // One write-clock cycle; a bit counts as accepted when in_ready is high at its edge
  task automatic wr_cycle(input bit en, input bit b, output bit acc);
    @(negedge wr_clk);
    wr_en = en; wr_bit = b;
    acc = en && in_ready;
    if (acc) begin expq[qt % 8192] = b; qt++; end
  endtask

  // One read-clock cycle; the bit shown is consumed when out_ready is high at its edge
  task automatic rd_cycle(input bit en, output bit popped);
    @(negedge rd_clk);
    rd_en = en;
    popped = en && out_ready;
    if (popped) begin
      if (qh == qt) chk(0, "R2 extra bit delivered", 1, 0);
      else begin
        chk(rd_bit == expq[qh % 8192], "R1 bit order", int'(rd_bit), int'(expq[qh % 8192]));
        qh++;
      end
    end
  endtask

  task automatic wr_idle(input int n);
    bit a;
    for (int k = 0; k < n; k++) wr_cycle(0, 0, a);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; wr_bit = 0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1;
    qh = 0; qt = 0;
    wr_idle(6);
  endtask

  task automatic t_reset_state();
    chk(in_ready == 1, "R9 in_ready after reset", int'(in_ready), 1);
    chk(out_ready == 0, "R9 out_ready after reset", int'(out_ready), 0);
    chk(half_full == 0, "R9 half_full after reset", int'(half_full), 0);
    chk(near_edge == 1, "R9 near_edge after reset", int'(near_edge), 1);
  endtask

  // Fill one bit at a time; check the flags at every stored count
  task automatic t_fill_flags();
    bit a;
    int acc_n = 0;
    for (int w = 1; w <= DEPTH + 1; w++) begin
      int st;
      wr_cycle(1, pat(w), a);
      if (a) acc_n++;
      wr_cycle(0, 0, a);
      wr_idle(12);
      st = w - 1;
      chk(half_full == (st >= DEPTH / 2), "R6 half_full level", int'(half_full), int'(st >= DEPTH / 2));
      chk(near_edge == (st <= NEAR || DEPTH - st <= NEAR), "R7 near_edge level",
          int'(near_edge), int'(st <= NEAR || DEPTH - st <= NEAR));
    end
    chk(acc_n == DEPTH + 1, "R1 bits accepted into empty block", acc_n, DEPTH + 1);
    chk(in_ready == 0, "R1 in_ready low when full", int'(in_ready), 0);
    chk(out_ready == 1, "R8 output valid when full", int'(out_ready), 1);
    // R2: writes against a low in_ready must not enter
    for (int k = 0; k < 6; k++) wr_cycle(1, 1'b1, a);
    wr_cycle(0, 0, a);
    wr_idle(10);
    chk(in_ready == 0, "R2 still full after refused writes", int'(in_ready), 0);
  endtask

  // R5: one read from a full block frees room after two write edges
  task automatic t_ir_latency();
    bit p;
    int n = 0;
    rd_cycle(1, p);
    chk(p == 1, "R5 read taken from full block", int'(p), 1);
    @(posedge rd_clk); #1 rd_en = 0;
    while (!in_ready && n < 20) begin @(posedge wr_clk); n++; #1; end
    chk(n == 2, "R5 write edges until in_ready", n, 2);
  endtask

  task automatic t_drain();
    bit p;
    for (int k = 0; k < 3 * DEPTH; k++) rd_cycle(1, p);
    rd_cycle(0, p);
    wr_idle(10);
    chk(qh == qt, "R2 all accepted bits delivered and no more", qt - qh, 0);
    chk(out_ready == 0, "R3 out_ready low when drained", int'(out_ready), 0);
    chk(half_full == 0 && near_edge == 1, "R6 R7 flags when drained", int'({half_full, near_edge}), 1);
  endtask

  // R3: reads on empty are ignored; R4: latency of the first bit; R8: fall-through
  task automatic t_empty_reads();
    bit p;
    int n = 0;
    for (int k = 0; k < 10; k++) rd_cycle(1, p);
    rd_cycle(0, p);
    chk(out_ready == 0, "R3 out_ready stays low on empty reads", int'(out_ready), 0);
    @(negedge wr_clk); wr_en = 1; wr_bit = 1;
    expq[qt % 8192] = 1; qt++;
    @(posedge wr_clk); #1 wr_en = 0;
    while (!out_ready && n < 20) begin @(posedge rd_clk); n++; #1; end
    chk(n == 4, "R4 read edges until out_ready", n, 4);
    chk(rd_bit == 1, "R3 first bit after ignored reads", int'(rd_bit), 1);
    begin
      bit a;
      wr_cycle(1, 0, a); wr_cycle(1, 1, a); wr_cycle(0, 0, a);
    end
    wr_idle(15);
    rd_cycle(1, p);
    rd_cycle(0, p);
    wr_idle(3);
    chk(out_ready == 1 && rd_bit == 0, "R8 next bit falls through", int'({out_ready, rd_bit}), 2'b10);
    rd_cycle(1, p); rd_cycle(1, p); rd_cycle(0, p);
    chk(qh == qt, "R8 all bits read", qt - qh, 0);
  endtask

  // R1: long stream with both sides active and read back-pressure
  task automatic t_stream();
    int rcvd = 0;
    fork
      begin
        int i = 0;
        bit a;
        while (i < 400) begin wr_cycle(1, pat(i * 7 + 1), a); if (a) i++; end
        wr_cycle(0, 0, a);
      end
      begin
        int g = 0;
        bit p;
        while (rcvd < 400 && g < 4000) begin
          rd_cycle((g % 3) != 0, p);
          if (p) rcvd++;
          g++;
        end
        rd_cycle(0, p);
      end
    join
    chk(rcvd == 400, "R1 stream bits delivered", rcvd, 400);
  endtask

  // R9: reset while holding data empties the block
  task automatic t_reset_with_data();
    bit a;
    for (int k = 0; k < 20; k++) wr_cycle(1, 1, a);
    wr_cycle(0, 0, a);
    wr_idle(12);
    chk(out_ready == 1, "R9 data present before reset", int'(out_ready), 1);
    do_reset();
    wr_idle(4);
    chk(out_ready == 0 && in_ready == 1, "R9 state cleared by reset", int'({out_ready, in_ready}), 1);
    chk(half_full == 0 && near_edge == 1, "R9 flags cleared by reset", int'({half_full, near_edge}), 1);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_fill_flags();
    t_ir_latency();
    t_drain();
    t_empty_reads();
    t_stream();
    t_reset_with_data();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule